// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block sits beside a processor core and chooses which of sixteen event levels the core should service next. Level 0 has the highest priority and level 15 the lowest. The fixed order is:

- level 0: debug-halt
- level 1: reset
- level 2: non-maskable (either a watchdog line or an external pin)
- level 3: synchronous exception
- level 4: the global-enable slot, which never carries a request of its own
- level 5: hardware error
- level 6: core timer
- levels 7 to 15: nine general-purpose lines

Levels 14 and 15 are normally raised by software. Each request line is latched into a pending bit when it rises.

A pending level is offered to the core only when all of the following hold:
- it is enabled;
- its number is strictly lower than every level already in service;
- it is the lowest-numbered level that meets the first two conditions.

Events therefore nest. The core takes the offered level with an acknowledge, which moves it from pending to in service. Later, the core returns from a named level, which removes only that level from service.

A small register port gives software the following access:
- read and write the per-level enable mask;
- read the pending and in-service vectors;
- raise the two software levels;
- set or clear the global enable.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After reset the pending, in-service, mask and global-enable state are all zero, and no event is offered.
- R2: A request input sets its pending bit only on a low-to-high transition. Holding the input high sets the bit once. The non-maskable level is raised by a rising edge of the OR of its watchdog and pin inputs.
- R3: The offered level is the lowest-numbered eligible level. Inputs map to levels as follows: debug-halt 0, reset 1, non-maskable 2, exception 3, hardware error 5, timer 6, and gp_req_i[k] to level 7+k.
- R4: Levels 0 to 3 ignore the mask and the global enable. Levels 5 to 15 are eligible only when their mask bit is 1 and the global enable is 1.
- R5: A level is offered only if its number is strictly lower than every level in service. A level equal to or higher-numbered than the innermost in-service level waits.
- R6: An acknowledge while an event is offered clears that level's pending bit and sets its in-service bit at the next clock edge. An acknowledge with nothing offered changes nothing.
- R7: A return for level L clears only in-service bit L. All other in-service bits keep their values.
- R8: The register address selects the data as follows. Reads are combinational.
  - Address 0: mask. Bits 5 to 15 are writable; bits 0 to 4 read 0.
  - Address 1: pending vector.
  - Address 2: in-service vector (writes are ignored).
  - Address 3: global enable in bit 0.
- R9: A write to address 1 sets pending bits 14 and 15 wherever the written data has a 1 in bits 14 and 15. All other written bits are ignored.
- R10: Whenever no event is offered, the level output is 0.
- R11: Level 4 is never pending and never in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emu_req_i | input | 1 | Debug-halt request (level 0) |
| rst_evt_req_i | input | 1 | Reset event request (level 1) |
| nmi_wdog_i | input | 1 | Non-maskable request from watchdog (level 2) |
| nmi_pin_i | input | 1 | Non-maskable request from pin (level 2) |
| excpt_req_i | input | 1 | Synchronous exception request (level 3) |
| hwerr_req_i | input | 1 | Hardware error request (level 5) |
| tmr_req_i | input | 1 | Core timer request (level 6) |
| gp_req_i | input | 9 | General-purpose requests, bit k to level 7+k |
| take_req_o | output | 1 | An event is offered to the core |
| take_lvl_o | output | 4 | Offered level, 0 when none |
| take_ack_i | input | 1 | Core takes the offered event |
| ret_valid_i | input | 1 | Core returns from a level |
| ret_lvl_i | input | 4 | Level being returned from |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |

## Verification
A lost or stale in-service bit changes which level the core is offered. A missing bit lets an equal or lower-priority event through on the very next cycle. A stuck bit blocks every later event at or below that level until the matching return. A wrong pending bit shows as a missing or phantom request one cycle after the input edge or the acknowledge. A mask or global-enable fault appears on the offer outputs in the cycle after the register write. Because of this, the bench checks the offer outputs after every acknowledge and every return, and it reads back the pending and in-service vectors at the points where nesting changes.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_LVL  = 16;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int NUM_GP   = 9;
  localparam int REG_AW   = 2;

  localparam int LVL_EMU  = 0;
  localparam int LVL_RST  = 1;
  localparam int LVL_NMI  = 2;
  localparam int LVL_EXC  = 3;
  localparam int LVL_GIE  = 4;
  localparam int LVL_HWE  = 5;
  localparam int LVL_TMR  = 6;
  localparam int LVL_GP0  = 7;
  localparam int LVL_SW0  = 14;

  typedef logic [NUM_LVL-1:0] lvl_vec_t;

  localparam lvl_vec_t ONE_HOT1    = lvl_vec_t'(1);
  localparam lvl_vec_t UNMASKABLE  = (ONE_HOT1 << LVL_GIE) - ONE_HOT1;
  localparam lvl_vec_t SLOT_BIT    = ONE_HOT1 << LVL_GIE;
  localparam lvl_vec_t MASK_WR     = ~((ONE_HOT1 << LVL_HWE) - ONE_HOT1);
  localparam lvl_vec_t SW_SET_BITS = ~((ONE_HOT1 << LVL_SW0) - ONE_HOT1);

  typedef enum logic [REG_AW-1:0] {
    REG_MASK = 2'd0,
    REG_PEND = 2'd1,
    REG_SVC  = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_pend_reg.sv
module evt_pend_reg
  import evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_vec_t raw_i,
  input  lvl_vec_t sw_set_i,
  input  lvl_vec_t clr_i,
  output lvl_vec_t pend_o
);
  lvl_vec_t prev_q, pend_q, rise;

  assign rise = raw_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= raw_i;
      // new edge wins over a same-cycle clear
      pend_q <= ((pend_q & ~clr_i) | rise | sw_set_i) & ~SLOT_BIT;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
(
  input  lvl_vec_t         pend_i,
  input  lvl_vec_t         svc_i,
  input  lvl_vec_t         mask_i,
  input  logic             gie_i,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o
);
  lvl_vec_t en, blk, elig;

  assign en = pend_i & ~SLOT_BIT & (UNMASKABLE | (mask_i & {NUM_LVL{gie_i}}));

  // blk[i]: some level at or above priority i is in service
  assign blk[0] = svc_i[0];
  for (genvar i = 1; i < NUM_LVL; i++) begin : g_blk
    assign blk[i] = blk[i-1] | svc_i[i];
  end

  assign elig  = en & ~blk;
  assign req_o = |elig;

  always_comb begin
    lvl_o = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (elig[i]) lvl_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/evt_svc_stack.sv
module evt_svc_stack
  import evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_vec_t set_i,
  input  lvl_vec_t clr_i,
  output lvl_vec_t svc_o
);
  lvl_vec_t svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= '0;
    else         svc_q <= (svc_q & ~clr_i) | set_i;
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl
  import evt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  emu_req_i,
  input  logic                  rst_evt_req_i,
  input  logic                  nmi_wdog_i,
  input  logic                  nmi_pin_i,
  input  logic                  excpt_req_i,
  input  logic                  hwerr_req_i,
  input  logic                  tmr_req_i,
  input  logic [NUM_GP-1:0]     gp_req_i,
  output logic                  take_req_o,
  output logic [LVL_W-1:0]      take_lvl_o,
  input  logic                  take_ack_i,
  input  logic                  ret_valid_i,
  input  logic [LVL_W-1:0]      ret_lvl_i,
  input  logic                  reg_we_i,
  input  logic [REG_AW-1:0]     reg_addr_i,
  input  logic [NUM_LVL-1:0]    reg_wdata_i,
  output logic [NUM_LVL-1:0]    reg_rdata_o
);
  lvl_vec_t raw, sw_set, ack_vec, ret_vec;
  lvl_vec_t pend_q, svc_q, mask_q;
  logic     gie_q;
  logic     ack_fire;

  always_comb begin
    raw = '0;
    raw[LVL_EMU] = emu_req_i;
    raw[LVL_RST] = rst_evt_req_i;
    raw[LVL_NMI] = nmi_wdog_i | nmi_pin_i;
    raw[LVL_EXC] = excpt_req_i;
    raw[LVL_HWE] = hwerr_req_i;
    raw[LVL_TMR] = tmr_req_i;
    raw[LVL_GP0 +: NUM_GP] = gp_req_i;
  end

  assign ack_fire = take_ack_i & take_req_o;
  assign ack_vec  = ack_fire ? (ONE_HOT1 << take_lvl_o) : '0;
  assign ret_vec  = ret_valid_i ? (ONE_HOT1 << ret_lvl_i) : '0;
  assign sw_set   = (reg_we_i && reg_addr_i == REG_PEND) ? (reg_wdata_i & SW_SET_BITS) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_addr_i == REG_MASK) mask_q <= reg_wdata_i & MASK_WR;
      if (reg_addr_i == REG_CTRL) gie_q  <= reg_wdata_i[0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      REG_MASK: reg_rdata_o = mask_q;
      REG_PEND: reg_rdata_o = pend_q;
      REG_SVC:  reg_rdata_o = svc_q;
      REG_CTRL: reg_rdata_o = {{(NUM_LVL-1){1'b0}}, gie_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  evt_pend_reg u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (raw),
    .sw_set_i (sw_set),
    .clr_i    (ack_vec),
    .pend_o   (pend_q)
  );

  evt_svc_stack u_svc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ack_vec),
    .clr_i  (ret_vec),
    .svc_o  (svc_q)
  );

  evt_arbiter u_arb (
    .pend_i (pend_q),
    .svc_i  (svc_q),
    .mask_i (mask_q),
    .gie_i  (gie_q),
    .req_o  (take_req_o),
    .lvl_o  (take_lvl_o)
  );
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk
  import evt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             take_req_o,
  input logic [LVL_W-1:0] take_lvl_o,
  input logic             take_ack_i,
  input logic             ret_valid_i,
  input logic [LVL_W-1:0] ret_lvl_i,
  input lvl_vec_t         pend_q,
  input lvl_vec_t         svc_q,
  input lvl_vec_t         mask_q,
  input logic             gie_q
);
  // R10
  assert_idle_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_req_o |-> take_lvl_o == '0);

  // R5
  assert_strict_preempt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_req_o |-> (svc_q & ((ONE_HOT1 << take_lvl_o) | ((ONE_HOT1 << take_lvl_o) - ONE_HOT1))) == '0);

  // R6
  assert_ack_enters_service_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_req_o && take_ack_i && !(ret_valid_i && ret_lvl_i == take_lvl_o))
    |=> svc_q[$past(take_lvl_o)]);

  // R7
  assert_return_clears_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !(take_req_o && take_ack_i))
    |=> svc_q == ($past(svc_q) & ~(ONE_HOT1 << $past(ret_lvl_i))));

  // R11
  assert_slot_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[LVL_GIE] && !svc_q[LVL_GIE]);

  // R4
  assert_masked_not_offered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_req_o && take_lvl_o >= LVL_W'(LVL_HWE)) |-> (gie_q && mask_q[take_lvl_o]));
endmodule

bind nest_evt_ctrl evt_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .take_req_o  (take_req_o),
  .take_lvl_o  (take_lvl_o),
  .take_ack_i  (take_ack_i),
  .ret_valid_i (ret_valid_i),
  .ret_lvl_i   (ret_lvl_i),
  .pend_q      (pend_q),
  .svc_q       (svc_q),
  .mask_q      (mask_q),
  .gie_q       (gie_q)
);

// File: tb/nest_evt_ctrl_test.sv
module nest_evt_ctrl_test;
  import evt_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic emu = 0, rste = 0, wdog = 0, pin = 0, exc = 0, hwe = 0, tmr = 0;
  logic [NUM_GP-1:0] gp = '0;
  logic take_req;
  logic [LVL_W-1:0] take_lvl;
  logic ack = 0, ret_v = 0;
  logic [LVL_W-1:0] ret_l = '0;
  logic we = 0;
  logic [REG_AW-1:0] addr = '0;
  logic [NUM_LVL-1:0] wdata = '0, rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string rid; bit is_rd; logic [15:0] exp; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  nest_evt_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .emu_req_i(emu), .rst_evt_req_i(rste), .nmi_wdog_i(wdog), .nmi_pin_i(pin),
    .excpt_req_i(exc), .hwerr_req_i(hwe), .tmr_req_i(tmr), .gp_req_i(gp),
    .take_req_o(take_req), .take_lvl_o(take_lvl), .take_ack_i(ack),
    .ret_valid_i(ret_v), .ret_lvl_i(ret_l),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // monitor: compare queued expectations shortly after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      act = e.is_rd ? rdata : {11'd0, take_req, take_lvl};
      n_chk++;
      if (act !== e.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.rid, act, e.exp);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic out(string rid, bit r, int l);
    exp_t e;
    e.rid = rid; e.is_rd = 0; e.exp = {11'd0, r, 4'(l)};
    q.push_back(e);
  endtask

  task automatic rd(string rid, int a, logic [15:0] x);
    exp_t e;
    addr = 2'(a);
    e.rid = rid; e.is_rd = 1; e.exp = x;
    q.push_back(e);
    cyc();
  endtask

  task automatic wr(int a, logic [15:0] d);
    we = 1; addr = 2'(a); wdata = d;
    cyc();
    we = 0;
  endtask

  task automatic take();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic give_back(int l);
    ret_v = 1; ret_l = 4'(l); cyc(); ret_v = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    // R1 / R10
    out("R1 idle after reset", 0, 0);
    rd("R1 mask", 0, 16'h0000);
    rd("R1 pending", 1, 16'h0000);
    rd("R1 in-service", 2, 16'h0000);
    rd("R1 gie", 3, 16'h0000);

    // R4: gp level 7 masked by default
    gp[0] = 1; cyc();
    out("R4 masked level waits", 0, 0);
    // R3/R4: exception ignores mask and gie
    exc = 1; cyc();
    out("R4 exception unmaskable", 1, 3);
    take();
    rd("R6 exception in service", 2, 16'h0008);
    repeat (3) cyc();
    rd("R2 held input no re-pend", 1, 16'h0080);
    // R5: nmi preempts exception
    wdog = 1; cyc();
    out("R5 nmi preempts", 1, 2);
    take();
    rd("R6 nested service", 2, 16'h000C);
    wdog = 0; exc = 0; cyc();
    pin = 1; cyc();
    out("R5 equal level waits", 0, 0);
    rd("R2 pin raises nmi", 1, 16'h0084);
    give_back(2);
    out("R7 return re-opens level", 1, 2);
    take();
    give_back(3);
    rd("R7 only level 3 removed", 2, 16'h0004);
    out("R4 gp still masked", 0, 0);
    give_back(2);
    rd("R7 stack empty", 2, 16'h0000);

    // R8: mask and gie
    wr(0, 16'hFFFF);
    rd("R8 mask low bits read zero", 0, 16'hFFE0);
    out("R4 gie off blocks", 0, 0);
    wr(3, 16'h0001);
    rd("R8 gie reads back", 3, 16'h0001);
    out("R3 gp0 maps to level 7", 1, 7);
    // R9 software raise
    wr(1, 16'hFFFF);
    rd("R9 only sw bits set", 1, 16'hC080);
    take();
    out("R5 lower priority waits", 0, 0);
    rd("R6 pending cleared on ack", 1, 16'hC000);
    hwe = 1; cyc();
    out("R3 hwerr level 5 preempts", 1, 5);
    wr(0, 16'hFFDF);
    out("R4 mask bit 5 clear", 0, 0);
    wr(0, 16'hFFFF);
    out("R4 mask bit 5 set", 1, 5);
    wr(3, 16'h0000);
    out("R4 gie clear", 0, 0);
    emu = 1; cyc();
    out("R3 emu level 0", 1, 0);
    take();
    out("R5 nothing above 0", 0, 0);
    give_back(0);
    give_back(7);
    out("R4 gie still off", 0, 0);
    wr(3, 16'h0001);
    out("R3 level 5 before 14", 1, 5);
    take(); give_back(5);
    out("R3 level 14 next", 1, 14);
    take(); give_back(14);
    out("R3 level 15 next", 1, 15);
    take(); give_back(15);
    out("R10 idle level zero", 0, 0);
    rd("R11 pending empty", 1, 16'h0000);

    emu = 0; hwe = 0; gp = '0; pin = 0; cyc();
    rste = 1; pin = 1; gp[8] = 1; cyc();
    out("R3 reset beats nmi", 1, 1);
    take();
    out("R5 nested under reset", 0, 0);
    give_back(1);
    out("R3 nmi after reset", 1, 2);
    take(); give_back(2);
    out("R3 gp8 maps to level 15", 1, 15);
    take(); give_back(15);
    out("R10 idle again", 0, 0);
    take();
    rd("R6 ack while idle ignored", 2, 16'h0000);
    wr(2, 16'hFFFF);
    rd("R8 in-service not writable", 2, 16'h0000);
    rd("R11 slot never pending", 1, 16'h0000);

    cyc(); cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule